// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small data cache that sits between a core's load/store port and a next-level memory. It has two ways per set and a 32-bit byte address. A lookup reads both ways of the indexed set in parallel. A hit completes in the same cycle the request is presented, so a load returns its word at once and a store merges its enabled bytes into the block. Any request that cannot complete raises a combinational stall. The core holds the request steady while the stall is high and retries it on each cycle.

On a miss, a controller records the set, tag and victim way. The victim is the way named by the set's single least-recently-used bit. The controller then asks the next level for the whole block. If the victim is dirty, its block and address are copied into a one-entry writeback buffer at the moment the fill request goes out. The buffer starts draining only after the fill has been installed and the controller is idle again. A store miss allocates the block first; the retried store then hits and marks the block dirty. Both memory-side transfers move a whole block in a single beat.

Top module: `cache_wb_2way`

## Requirements
- R1: With the default parameters (4-word blocks of 32-bit words, 8 sets), address bits [3:0] select the byte within the block, bits [3:2] select the word, bits [6:4] select the set, and bits [31:7] form the tag. Two addresses in the same 16-byte block share one frame.
- R2: A request hits when either way of its set is valid and holds a matching tag. A hit keeps stall_o low in the same cycle, a load returns its word on rdata_o in that cycle, and at most one way can match.
- R3: Each set keeps one LRU bit, and every hit and every fill points it at the other way. On a miss the way it names is replaced.
- R4: A store hit writes only the bytes of the addressed word whose be_i bit is set (be_i[k] covers bits 8k+7:8k) and marks the block dirty.
- R5: Replacing a clean or invalid block produces no writeback.
- R6: When a dirty block is replaced, the fill request for the new block is raised first and the victim is copied into the writeback buffer. The writeback request rises only after the fill has been installed. It carries the victim's block-aligned address, and word k of the block occupies bits 32k+31:32k of the data bus.
- R7: A store miss fills the block from the next level and then merges the store into it. The block then becomes dirty and is written back when it is later evicted.
- R8: stall_o stays high while a miss is being served. It falls in the first cycle after the cycle in which mem_rd_valid_i returns the fill.
- R9: A miss whose dirty victim needs the writeback buffer while the buffer is full waits until the buffer has drained. A miss to the block held in the buffer also waits, so that it reads the written-back data.
- R10: Asynchronous reset clears every valid, dirty and LRU bit and leaves stall_o, mem_rd_req_o and mem_wr_req_o low. Any block cached before reset misses afterwards.
- R11: mem_rd_req_o stays high with a stable address until mem_rd_valid_i arrives. mem_wr_req_o stays high with a stable address and data until mem_wr_ack_i arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core request valid |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store data |
| be_i | input | 4 | Store byte enables |
| rdata_o | output | 32 | Load data, valid on a cycle with req_i high and stall_o low |
| stall_o | output | 1 | Request cannot complete this cycle |
| mem_rd_req_o | output | 1 | Block fill request |
| mem_rd_addr_o | output | 32 | Block-aligned fill address |
| mem_rd_valid_i | input | 1 | Fill data valid, one-cycle pulse |
| mem_rd_data_i | input | 128 | Fill block |
| mem_wr_req_o | output | 1 | Writeback request |
| mem_wr_addr_o | output | 32 | Block-aligned writeback address |
| mem_wr_data_o | output | 128 | Writeback block |
| mem_wr_ack_i | input | 1 | Writeback accepted, one-cycle pulse |

## Verification
Some properties are checked on every cycle: that at most one way matches, that both memory requests hold with stable payloads until answered, that the buffer is never loaded while full, that the writeback request does not rise while a fill is outstanding, and that an unchanged request stops stalling once the fill lands. Other behaviours only show up across whole access sequences, so the bench's scenarios cover them. These are the victim choice made by the LRU bit, byte-merged store data, a written-back block being read again through memory, the absence of traffic for clean evictions, and the ordering of fill, drain and the next miss when the buffer is busy.

// File: rtl/cache_wb_pkg.sv
package cache_wb_pkg;
  localparam int unsigned NUM_WAYS = 2;
  typedef enum logic {CTL_IDLE, CTL_FILL} ctl_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store
  import cache_wb_pkg::*;
#(
  parameter int unsigned SETS  = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned TAG_W = 25
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [TAG_W-1:0]    tag_i,
  output logic [NUM_WAYS-1:0] match_o,
  output logic                lru_o,
  output logic                vict_valid_o,
  output logic                vict_dirty_o,
  output logic [TAG_W-1:0]    vict_tag_o,
  input  logic                touch_i,
  input  logic                touch_way_i,
  input  logic                touch_store_i,
  input  logic                fill_i,
  input  logic [IDX_W-1:0]    fill_idx_i,
  input  logic                fill_way_i,
  input  logic [TAG_W-1:0]    fill_tag_i
);
  logic [TAG_W-1:0] tag_q   [NUM_WAYS][SETS];
  logic [SETS-1:0]  valid_q [NUM_WAYS];
  logic [SETS-1:0]  dirty_q [NUM_WAYS];
  logic [SETS-1:0]  lru_q;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    localparam logic WAY = 1'(w);
    assign match_o[w] = valid_q[w][idx_i] && (tag_q[w][idx_i] == tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[w] <= '0;
        dirty_q[w] <= '0;
      end else if (fill_i && fill_way_i == WAY) begin
        valid_q[w][fill_idx_i] <= 1'b1;
        dirty_q[w][fill_idx_i] <= 1'b0;
      end else if (touch_i && touch_store_i && touch_way_i == WAY) begin
        dirty_q[w][idx_i] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (fill_i && fill_way_i == WAY) tag_q[w][fill_idx_i] <= fill_tag_i;
    end
  end

  // lru bit names the way to evict next
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lru_q <= '0;
    else if (fill_i)  lru_q[fill_idx_i] <= ~fill_way_i;
    else if (touch_i) lru_q[idx_i] <= ~touch_way_i;
  end

  assign lru_o        = lru_q[idx_i];
  assign vict_valid_o = valid_q[lru_q[idx_i]][idx_i];
  assign vict_dirty_o = dirty_q[lru_q[idx_i]][idx_i];
  assign vict_tag_o   = tag_q[lru_q[idx_i]][idx_i];

  // R2
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_o));
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store
  import cache_wb_pkg::*;
#(
  parameter int unsigned SETS        = 8,
  parameter int unsigned IDX_W       = 3,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned BLOCK_WORDS = 4,
  parameter int unsigned WSEL_W      = 2,
  localparam int unsigned BLK_W      = DATA_W * BLOCK_WORDS,
  localparam int unsigned BYTES      = DATA_W / 8
) (
  input  logic                             clk_i,
  input  logic [IDX_W-1:0]                 rd_idx_i,
  output logic [NUM_WAYS-1:0][BLK_W-1:0]   blk_o,
  input  logic                             fill_i,
  input  logic [IDX_W-1:0]                 fill_idx_i,
  input  logic                             fill_way_i,
  input  logic [BLK_W-1:0]                 fill_blk_i,
  input  logic                             st_i,
  input  logic                             st_way_i,
  input  logic [WSEL_W-1:0]                st_word_i,
  input  logic [DATA_W-1:0]                st_data_i,
  input  logic [BYTES-1:0]                 st_be_i
);
  logic [BLK_W-1:0] mem_q [NUM_WAYS][SETS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    localparam logic WAY = 1'(w);
    always_ff @(posedge clk_i) begin
      if (fill_i && fill_way_i == WAY) begin
        mem_q[w][fill_idx_i] <= fill_blk_i;
      end else if (st_i && st_way_i == WAY) begin
        for (int b = 0; b < int'(BYTES); b++) begin
          if (st_be_i[b])
            mem_q[w][rd_idx_i][int'(st_word_i)*DATA_W + b*8 +: 8] <= st_data_i[b*8 +: 8];
        end
      end
    end
    assign blk_o[w] = mem_q[w][rd_idx_i];
  end
endmodule

// File: rtl/cache_wb_buffer.sv
module cache_wb_buffer #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BLK_W  = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [BLK_W-1:0]  load_blk_i,
  input  logic              allow_i,
  input  logic              ack_i,
  output logic              full_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BLK_W-1:0]  blk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      req_o  <= 1'b0;
    end else if (load_i) begin
      full_o <= 1'b1;
    end else if (req_o && ack_i) begin
      full_o <= 1'b0;
      req_o  <= 1'b0;
    end else if (full_o && allow_i && !req_o) begin
      req_o  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      addr_o <= load_addr_i;
      blk_o  <= load_blk_i;
    end
  end

  // R9
  load_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !full_o);
  // R11
  wb_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(blk_o));
endmodule

// File: rtl/cache_wb_2way.sv
module cache_wb_2way
  import cache_wb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned BLOCK_WORDS = 4,
  parameter int unsigned SETS        = 8,
  localparam int unsigned BYTES      = DATA_W / 8,
  localparam int unsigned BOFF_W     = $clog2(BYTES),
  localparam int unsigned WSEL_W     = $clog2(BLOCK_WORDS),
  localparam int unsigned OFF_W      = BOFF_W + WSEL_W,
  localparam int unsigned IDX_W      = $clog2(SETS),
  localparam int unsigned TAG_W      = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned BLK_W      = DATA_W * BLOCK_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BYTES-1:0]  be_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              stall_o,
  output logic              mem_rd_req_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_valid_i,
  input  logic [BLK_W-1:0]  mem_rd_data_i,
  output logic              mem_wr_req_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [BLK_W-1:0]  mem_wr_data_o,
  input  logic              mem_wr_ack_i
);
  ctl_state_e state_q;
  logic [IDX_W-1:0] miss_idx_q;
  logic [TAG_W-1:0] miss_tag_q;
  logic             miss_way_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;
  logic [BOFF_W-1:0] unused_boff;
  assign idx         = addr_i[OFF_W +: IDX_W];
  assign tag         = addr_i[ADDR_W-1 -: TAG_W];
  assign wsel        = addr_i[BOFF_W +: WSEL_W];
  assign unused_boff = addr_i[BOFF_W-1:0];

  logic [NUM_WAYS-1:0]            match;
  logic                           lru, vict_valid, vict_dirty;
  logic [TAG_W-1:0]               vict_tag;
  logic [NUM_WAYS-1:0][BLK_W-1:0] way_blk;
  logic                           wb_full;

  logic idle, hit_any, hit_way, core_hit, need_wb, wb_conflict, miss_go, fill_done;
  assign idle      = (state_q == CTL_IDLE);
  assign hit_any   = |match;
  assign hit_way   = match[1];
  assign core_hit  = req_i && idle && hit_any;
  assign need_wb   = vict_valid && vict_dirty;
  // block already parked in the buffer must drain before it is refetched
  assign wb_conflict = wb_full &&
      (need_wb || (mem_wr_addr_o[ADDR_W-1:OFF_W] == addr_i[ADDR_W-1:OFF_W]));
  assign miss_go   = req_i && idle && !hit_any && !wb_conflict;
  assign fill_done = (state_q == CTL_FILL) && mem_rd_valid_i;

  assign stall_o = req_i && !core_hit;
  assign rdata_o = way_blk[hit_way][int'(wsel)*DATA_W +: DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= CTL_IDLE;
      miss_idx_q <= '0;
      miss_tag_q <= '0;
      miss_way_q <= 1'b0;
    end else begin
      case (state_q)
        CTL_IDLE: if (miss_go) begin
          state_q    <= CTL_FILL;
          miss_idx_q <= idx;
          miss_tag_q <= tag;
          miss_way_q <= lru;
        end
        CTL_FILL: if (mem_rd_valid_i) state_q <= CTL_IDLE;
        default:  state_q <= CTL_IDLE;
      endcase
    end
  end

  assign mem_rd_req_o  = (state_q == CTL_FILL);
  assign mem_rd_addr_o = {miss_tag_q, miss_idx_q, {OFF_W{1'b0}}};

  cache_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .idx_i         (idx),
    .tag_i         (tag),
    .match_o       (match),
    .lru_o         (lru),
    .vict_valid_o  (vict_valid),
    .vict_dirty_o  (vict_dirty),
    .vict_tag_o    (vict_tag),
    .touch_i       (core_hit),
    .touch_way_i   (hit_way),
    .touch_store_i (we_i),
    .fill_i        (fill_done),
    .fill_idx_i    (miss_idx_q),
    .fill_way_i    (miss_way_q),
    .fill_tag_i    (miss_tag_q)
  );

  cache_data_store #(.SETS(SETS), .IDX_W(IDX_W), .DATA_W(DATA_W),
                     .BLOCK_WORDS(BLOCK_WORDS), .WSEL_W(WSEL_W)) u_data (
    .clk_i,
    .rd_idx_i   (idx),
    .blk_o      (way_blk),
    .fill_i     (fill_done),
    .fill_idx_i (miss_idx_q),
    .fill_way_i (miss_way_q),
    .fill_blk_i (mem_rd_data_i),
    .st_i       (core_hit && we_i),
    .st_way_i   (hit_way),
    .st_word_i  (wsel),
    .st_data_i  (wdata_i),
    .st_be_i    (be_i)
  );

  cache_wb_buffer #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_wbuf (
    .clk_i, .rst_ni,
    .load_i      (miss_go && need_wb),
    .load_addr_i ({vict_tag, idx, {OFF_W{1'b0}}}),
    .load_blk_i  (way_blk[lru]),
    .allow_i     (idle),
    .ack_i       (mem_wr_ack_i),
    .full_o      (wb_full),
    .req_o       (mem_wr_req_o),
    .addr_o      (mem_wr_addr_o),
    .blk_o       (mem_wr_data_o)
  );

  // R11
  fill_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o && !mem_rd_valid_i |=> mem_rd_req_o && $stable(mem_rd_addr_o));
  // R6
  drain_after_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o |-> !$rose(mem_wr_req_o));
  // R8
  stall_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o && mem_rd_valid_i && req_i |=>
      !(req_i && $stable(addr_i) && $stable(we_i)) || !stall_o);
endmodule

// File: tb/sim_cache_wb_2way.sv
module sim_cache_wb_2way;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0, we_i = 1'b0;
  logic [31:0]  addr_i = '0, wdata_i = '0;
  logic [3:0]   be_i = '0;
  logic [31:0]  rdata_o;
  logic         stall_o;
  logic         mem_rd_req_o, mem_rd_valid_i;
  logic [31:0]  mem_rd_addr_o;
  logic [127:0] mem_rd_data_i;
  logic         mem_wr_req_o, mem_wr_ack_i;
  logic [31:0]  mem_wr_addr_o;
  logic [127:0] mem_wr_data_o;

  always #5 clk_i = ~clk_i;

  cache_wb_2way u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, done = 0;
  int rd_lat = 2, wr_lat = 3;
  logic [31:0] mem [1024];
  logic [31:0] ref_mem [1024];

  // next-level memory model and logs
  logic rd_busy = 0, wr_busy = 0, fill_edge = 0;
  int rd_wait, wr_wait;
  logic [31:0] rd_a, wr_a;
  logic [127:0] wr_d;
  int n_freq = 0, n_fdone = 0, n_wb = 0;
  int fill_start_log [32], fill_done_log [32];
  int wb_start_log [8], wb_ack_log [8];
  logic [31:0] wb_addr_log [8], wb_w1_log [8];

  always @(posedge clk_i) begin
    cyc++;
    fill_edge <= rst_ni && mem_rd_req_o && mem_rd_valid_i;
    if (!rst_ni) begin
      mem_rd_valid_i <= 0; mem_wr_ack_i <= 0; rd_busy = 0; wr_busy = 0;
    end else begin
      if (mem_rd_req_o && mem_rd_valid_i) begin fill_done_log[n_fdone] = cyc; n_fdone++; end
      mem_rd_valid_i <= 0;
      if (rd_busy) begin
        if (rd_wait == 0) begin
          mem_rd_valid_i <= 1;
          for (int k = 0; k < 4; k++) mem_rd_data_i[k*32 +: 32] <= mem[rd_a[11:2] + 10'(k)];
          rd_busy = 0;
        end else rd_wait--;
      end else if (mem_rd_req_o && !mem_rd_valid_i) begin
        rd_busy = 1; rd_wait = rd_lat; rd_a = mem_rd_addr_o;
        fill_start_log[n_freq] = cyc; n_freq++;
      end
      mem_wr_ack_i <= 0;
      if (wr_busy) begin
        if (wr_wait == 0) begin
          mem_wr_ack_i <= 1;
          for (int k = 0; k < 4; k++) mem[wr_a[11:2] + 10'(k)] = wr_d[k*32 +: 32];
          wb_ack_log[n_wb-1] = cyc;
          wr_busy = 0;
        end else wr_wait--;
      end else if (mem_wr_req_o && !mem_wr_ack_i) begin
        wr_busy = 1; wr_wait = wr_lat; wr_a = mem_wr_addr_o; wr_d = mem_wr_data_o;
        wb_addr_log[n_wb] = mem_wr_addr_o; wb_w1_log[n_wb] = mem_wr_data_o[63:32];
        wb_start_log[n_wb] = cyc; n_wb++;
      end
    end
  end

  // handshake hold monitor
  int drops = 0;
  logic p_rd = 0, p_rdv = 0, p_wr = 0, p_wra = 0;
  logic [31:0] p_wa;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (p_rd && !p_rdv && !mem_rd_req_o) drops++;
      if (p_wr && !p_wra && (!mem_wr_req_o || mem_wr_addr_o != p_wa)) drops++;
    end
    p_rd = rst_ni && mem_rd_req_o; p_rdv = mem_rd_valid_i;
    p_wr = rst_ni && mem_wr_req_o; p_wra = mem_wr_ack_i; p_wa = mem_wr_addr_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rd, output int stalls,
                        output logic late);
    @(negedge clk_i);
    req_i = 1; we_i = we; addr_i = a; wdata_i = d; be_i = be;
    stalls = 0; late = 0;
    #1;
    while (stall_o) begin
      if (fill_edge) late = 1;
      stalls++;
      @(negedge clk_i); #1;
    end
    if (stalls > 0 && !fill_edge) late = 1;
    rd = rdata_o;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
    if (we) for (int b = 0; b < 4; b++) if (be[b]) ref_mem[a[11:2]][b*8 +: 8] = d[b*8 +: 8];
  endtask

  // {we, be[3:0], expect_hit, addr[11:0], wdata}
  localparam logic [49:0] VEC [18] = '{
    {1'b0, 4'hF, 1'b0, 12'h000, 32'h0},
    {1'b0, 4'hF, 1'b1, 12'h004, 32'h0},
    {1'b0, 4'hF, 1'b0, 12'h080, 32'h0},
    {1'b0, 4'hF, 1'b1, 12'h000, 32'h0},
    {1'b1, 4'hF, 1'b1, 12'h084, 32'hDEADBEEF},
    {1'b0, 4'hF, 1'b0, 12'h100, 32'h0},
    {1'b0, 4'hF, 1'b0, 12'h008, 32'h0},
    {1'b0, 4'hF, 1'b0, 12'h084, 32'h0},
    {1'b1, 4'h3, 1'b1, 12'h008, 32'h00001234},
    {1'b0, 4'hF, 1'b1, 12'h008, 32'h0},
    {1'b1, 4'hF, 1'b0, 12'h204, 32'h55AA55AA},
    {1'b0, 4'hF, 1'b1, 12'h204, 32'h0},
    {1'b0, 4'hF, 1'b0, 12'h010, 32'h0},
    {1'b1, 4'h8, 1'b1, 12'h014, 32'h77000000},
    {1'b0, 4'hF, 1'b1, 12'h014, 32'h0},
    {1'b0, 4'hF, 1'b0, 12'h300, 32'h0},
    {1'b0, 4'hF, 1'b0, 12'h008, 32'h0},
    {1'b0, 4'hF, 1'b0, 12'h204, 32'h0}
  };

  initial begin
    logic [31:0] rd;
    int st;
    logic late;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 32'hC0DE_0000 | 32'(i * 4);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(!stall_o && !mem_rd_req_o && !mem_wr_req_o, "R10 idle in reset",
        {29'b0, stall_o, mem_rd_req_o, mem_wr_req_o}, 32'h0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < 18; i++) begin
      logic [49:0] v;
      v = VEC[i];
      access(v[49], {20'b0, v[43:32]}, v[31:0], v[48:45], rd, st, late);
      // R1 R2 R3 R7 hit/miss pattern follows block split and LRU victim choice
      chk((st == 0) == v[44], $sformatf("R3 hit pattern entry %0d", i),
          32'(st == 0), 32'(v[44]));
      if (!v[49])
        chk(rd == ref_mem[v[43:34]], $sformatf("R2 R4 load data entry %0d", i),
            rd, ref_mem[v[43:34]]);
      if (st > 0)
        chk(!late, $sformatf("R8 stall release entry %0d", i), 32'(late), 32'h0);
    end
    repeat (10) @(negedge clk_i);

    // R5: only dirty victims produced writebacks
    chk(n_wb == 3, "R5 writeback count", 32'(n_wb), 32'd3);
    chk(wb_addr_log[0] == 32'h080 && wb_addr_log[1] == 32'h000 && wb_addr_log[2] == 32'h200,
        "R7 writeback addresses", wb_addr_log[2], 32'h200);
    // R6 ordering and payload of first dirty eviction (fill index 3)
    chk(fill_start_log[3] < wb_start_log[0], "R6 fill before drain request",
        32'(fill_start_log[3]), 32'(wb_start_log[0]));
    chk(wb_start_log[0] > fill_done_log[3], "R6 drain after install",
        32'(wb_start_log[0]), 32'(fill_done_log[3]));
    chk(wb_w1_log[0] == 32'hDEADBEEF, "R6 writeback data word1", wb_w1_log[0], 32'hDEADBEEF);
    // R9 refetch of parked block waited for the drain
    chk(fill_start_log[4] > wb_ack_log[0], "R9 refetch after drain",
        32'(fill_start_log[4]), 32'(wb_ack_log[0]));

    // R9 buffer busy: second dirty eviction waits for slow drain
    wr_lat = 30;
    access(1'b1, 32'h020, 32'h11111111, 4'hF, rd, st, late);
    access(1'b1, 32'h0A0, 32'h22222222, 4'hF, rd, st, late);
    access(1'b0, 32'h120, 32'h0, 4'hF, rd, st, late);
    chk(rd == ref_mem[32'h120 >> 2], "R2 load after eviction", rd, ref_mem[32'h120 >> 2]);
    access(1'b0, 32'h1A0, 32'h0, 4'hF, rd, st, late);
    chk(rd == ref_mem[32'h1A0 >> 2], "R9 load after wait", rd, ref_mem[32'h1A0 >> 2]);
    chk(fill_start_log[13] > wb_ack_log[3], "R9 miss waits for full buffer",
        32'(fill_start_log[13]), 32'(wb_ack_log[3]));
    access(1'b0, 32'h020, 32'h0, 4'hF, rd, st, late);
    chk(rd == 32'h11111111, "R7 store-miss data via memory", rd, 32'h11111111);
    repeat (80) @(negedge clk_i);
    chk(n_wb == 5, "R5 total writebacks", 32'(n_wb), 32'd5);
    chk(drops == 0, "R11 request hold", 32'(drops), 32'h0);

    // R10 reset mid-run drops cached blocks
    rst_ni = 0;
    @(negedge clk_i);
    chk(!stall_o && !mem_rd_req_o && !mem_wr_req_o, "R10 idle after reset",
        {29'b0, stall_o, mem_rd_req_o, mem_wr_req_o}, 32'h0);
    rst_ni = 1;
    for (int i = 0; i < 1024; i++) ref_mem[i] = mem[i];
    @(negedge clk_i);
    access(1'b0, 32'h0A4, 32'h0, 4'hF, rd, st, late);
    chk(st > 0, "R10 miss after reset", 32'(st), 32'h1);
    chk(rd == ref_mem[32'h0A4 >> 2], "R10 data after reset", rd, ref_mem[32'h0A4 >> 2]);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule